// File: doc/BRIEF.md
# Downstream Request Address Translator

This block sits between the decoded downstream request stream of a serial link controller and a memory-mapped bus master. Each incoming request brings a byte address, a byte length, an index naming the base address register window it hit, and a read/write flag. The block turns each request into one or more burst commands for the master, and reports unsupported reads to the completion path.

In endpoint mode, the translator rewrites the request address. It keeps the bits that fall inside the hit window and takes the bits above the window from a per-window translation entry. Software or boot logic loads the six entries through a simple write-only configuration port. In root-port mode, the window index is ignored and every address passes through unchanged.

Writes always leave as a single burst covering the whole length. Reads longer than the burst ceiling are cut into consecutive bursts. A request with a zero length, or with no window hit in endpoint mode, is unsupported. An unsupported read produces a completer-abort pulse. An unsupported write is silently dropped.

Top module: `dn_req_xlate`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0, ca_valid is 0, and every translation entry holds base 0 and mask 0, so an endpoint request to an unconfigured window maps to address 0.
- R2: In endpoint mode (rp_mode=0), with req_bar in 0..5, cmd_addr equals (base & ~mask) | (req_addr & mask) for the entry selected by req_bar.
- R3: In root-port mode (rp_mode=1), cmd_addr equals req_addr for any req_bar value, including 6 and 7.
- R4: A supported read of at most 512 bytes produces exactly one command with cmd_wr=0 and cmd_len equal to req_len. A read command never has a length of 0 or above 512.
- R5: A supported read longer than 512 bytes produces consecutive commands of 512 bytes each, followed by a final command carrying the remainder. Each command's address is the previous command's address plus 512.
- R6: While a split read still has sub-bursts left to issue, req_ready stays 0. No later request is issued before the last sub-burst of the split read.
- R7: A supported write produces exactly one command with cmd_wr=1, the translated address, and the full req_len, even when req_len exceeds 512.
- R8: A read with req_len=0, or, in endpoint mode, with req_bar of 6 or 7, yields no command. It gives a single one-cycle ca_valid pulse in the cycle after it is accepted.
- R9: A write that is unsupported under the R8 rules yields neither a command nor a ca_valid pulse.
- R10: While cmd_valid=1 and cmd_ready=0, cmd_valid, cmd_addr, cmd_len and cmd_wr hold their values into the next cycle.
- R11: A configuration write with cfg_idx of 6 or 7 changes no translation entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rp_mode | input | 1 | 1 = root-port pass-through, 0 = endpoint translation |
| cfg_we | input | 1 | Translation entry write strobe |
| cfg_idx | input | 3 | Entry to write (0..5) |
| cfg_base | input | 32 | Upper-address replacement value |
| cfg_mask | input | 32 | Window mask, ones over the kept low bits |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Request byte address |
| req_len | input | 13 | Request length in bytes |
| req_bar | input | 3 | Window hit index, 6 or 7 = no hit |
| req_wr | input | 1 | 1 = write, 0 = read |
| cmd_valid | output | 1 | Burst command present |
| cmd_ready | input | 1 | Master takes the command |
| cmd_addr | output | 32 | Burst start address |
| cmd_len | output | 13 | Burst length in bytes |
| cmd_wr | output | 1 | 1 = write burst, 0 = read burst |
| ca_valid | output | 1 | One-cycle completer-abort pulse |

## Verification
The bench drives three kinds of patterns and compares the translated address against an independently computed value:
- endpoint requests through windows with different mask widths, which separates correct merging from a plain pass-through or a plain base substitution;
- the same addresses in root-port mode, which separates the bypass from the translated path;
- the no-hit index 7 in root-port mode, which shows that the index is truly ignored.

Read lengths of 64, 512, 513 and 1300 bytes show where the split starts, how the addresses step and what length the remainder carries. A 1024-byte write shows that writes are never cut. Zero-length and no-hit requests of both kinds separate the abort path from the silent drop. A back-to-back request queued behind a split read shows that nothing overtakes the split.

// File: rtl/dnx_pkg.sv
package dnx_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 13;
    localparam int BAR_W  = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [BAR_W-1:0]  bar_t;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    // decoded downstream request
    typedef struct packed {
        addr_t addr;
        len_t  len;
        bar_t  bar;
        op_e   op;
    } dreq_t;

    // one window translation entry
    typedef struct packed {
        addr_t base;
        addr_t mask;
    } xent_t;

    // merge kept low bits of the request with the entry's upper bits
    function automatic addr_t remap(input addr_t a, input xent_t e);
        return (e.base & ~e.mask) | (a & e.mask);
    endfunction

    function automatic len_t clip(input len_t l, input len_t cap);
        return (l > cap) ? cap : l;
    endfunction

endpackage

// File: rtl/dnx_xlate_table.sv
module dnx_xlate_table
    import dnx_pkg::*;
#(
    parameter int NUM_BAR = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_we,
    input  bar_t  cfg_idx,
    input  addr_t cfg_base,
    input  addr_t cfg_mask,
    input  bar_t  rd_idx,
    output logic  rd_hit,
    output xent_t rd_ent
);

    localparam bar_t LAST_IDX = bar_t'(NUM_BAR - 1);

    xent_t tbl [NUM_BAR];

    for (genvar i = 0; i < NUM_BAR; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[i] <= '0;
            end else if (cfg_we && (cfg_idx == bar_t'(i))) begin
                tbl[i].base <= cfg_base;
                tbl[i].mask <= cfg_mask;
            end
        end

        // R11
        cfg_oob_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && (cfg_idx > LAST_IDX)) |=> $stable(tbl[i]));
    end

    always_comb begin
        rd_ent = '0;
        for (int i = 0; i < NUM_BAR; i++) begin
            if (rd_idx == bar_t'(i)) begin
                rd_ent = tbl[i];
            end
        end
    end

    assign rd_hit = (rd_idx <= LAST_IDX);

endmodule

// File: rtl/dnx_req_classify.sv
module dnx_req_classify
    import dnx_pkg::*;
(
    input  dreq_t req,
    input  logic  rp_mode,
    input  logic  hit,
    input  xent_t ent,
    output addr_t xaddr,
    output logic  bad
);

    logic len_zero;
    logic no_win;

    assign len_zero = (req.len == '0);
    assign no_win   = !rp_mode && !hit;
    assign bad      = len_zero || no_win;
    assign xaddr    = rp_mode ? req.addr : remap(req.addr, ent);

endmodule

// File: rtl/dnx_burst_gen.sv
module dnx_burst_gen
    import dnx_pkg::*;
#(
    parameter int MAX_BURST = 512
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    input  addr_t in_addr,
    input  len_t  in_len,
    input  op_e   in_op,
    input  logic  in_bad,
    output logic  cmd_valid,
    input  logic  cmd_ready,
    output addr_t cmd_addr,
    output len_t  cmd_len,
    output op_e   cmd_op,
    output logic  ca_valid
);

    localparam len_t  CAP  = len_t'(MAX_BURST);
    localparam addr_t STEP = addr_t'(MAX_BURST);

    len_t  rem;
    addr_t nxt_addr;
    len_t  first_len;
    len_t  next_len;
    logic  take;
    logic  drain;

    assign in_ready  = (rem == '0) && (!cmd_valid || cmd_ready);
    assign take      = in_valid && in_ready;
    assign drain     = cmd_valid && cmd_ready;
    assign first_len = clip(in_len, CAP);
    assign next_len  = clip(rem, CAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_len   <= '0;
            cmd_op    <= OP_RD;
            rem       <= '0;
            nxt_addr  <= '0;
            ca_valid  <= 1'b0;
        end else begin
            ca_valid <= 1'b0;
            if (take) begin
                if (in_bad) begin
                    cmd_valid <= 1'b0;
                    ca_valid  <= (in_op == OP_RD);
                end else if (in_op == OP_WR) begin
                    cmd_valid <= 1'b1;
                    cmd_addr  <= in_addr;
                    cmd_len   <= in_len;
                    cmd_op    <= OP_WR;
                    rem       <= '0;
                end else begin
                    cmd_valid <= 1'b1;
                    cmd_addr  <= in_addr;
                    cmd_len   <= first_len;
                    cmd_op    <= OP_RD;
                    rem       <= in_len - first_len;
                    nxt_addr  <= in_addr + STEP;
                end
            end else if (drain) begin
                if (rem != '0) begin
                    cmd_addr <= nxt_addr;
                    cmd_len  <= next_len;
                    rem      <= rem - next_len;
                    nxt_addr <= nxt_addr + STEP;
                end else begin
                    cmd_valid <= 1'b0;
                end
            end
        end
    end

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_op)));

    // R4
    rd_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == OP_RD)) |-> ((cmd_len != '0) && (cmd_len <= CAP)));

    // R5
    split_step_chk: assert property (@(posedge clk) disable iff (rst)
        (drain && (rem != '0)) |=>
            (cmd_valid && (cmd_addr == $past(cmd_addr) + STEP)));

    // R8
    ca_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ca_valid |-> $past(take && in_bad && (in_op == OP_RD)));

    // R8
    ca_nocmd_chk: assert property (@(posedge clk) disable iff (rst)
        ca_valid |-> !cmd_valid);

    // R7
    wr_len_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == OP_WR)) |-> (cmd_len != '0));

endmodule

// File: rtl/dn_req_xlate.sv
module dn_req_xlate
    import dnx_pkg::*;
#(
    parameter int NUM_BAR   = 6,
    parameter int MAX_BURST = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rp_mode,
    input  logic              cfg_we,
    input  logic [BAR_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [BAR_W-1:0]  req_bar,
    input  logic              req_wr,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_wr,
    output logic              ca_valid
);

    dreq_t req;
    logic  hit;
    xent_t ent;
    addr_t xaddr;
    logic  bad;
    op_e   cmd_op;

    assign req.addr = req_addr;
    assign req.len  = req_len;
    assign req.bar  = req_bar;
    assign req.op   = req_wr ? OP_WR : OP_RD;

    dnx_xlate_table #(.NUM_BAR(NUM_BAR)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_base (cfg_base),
        .cfg_mask (cfg_mask),
        .rd_idx   (req_bar),
        .rd_hit   (hit),
        .rd_ent   (ent)
    );

    dnx_req_classify u_cls (
        .req     (req),
        .rp_mode (rp_mode),
        .hit     (hit),
        .ent     (ent),
        .xaddr   (xaddr),
        .bad     (bad)
    );

    dnx_burst_gen #(.MAX_BURST(MAX_BURST)) u_bgen (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_addr   (xaddr),
        .in_len    (req.len),
        .in_op     (req.op),
        .in_bad    (bad),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .cmd_op    (cmd_op),
        .ca_valid  (ca_valid)
    );

    assign cmd_wr = (cmd_op == OP_WR);

    // R3
    rp_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (rp_mode && req_valid && req_ready && (req_len != '0)) |=> (cmd_addr == $past(req_addr)));

endmodule

// File: tb/sim_dn_req_xlate.sv
`timescale 1ns/1ps
module sim_dn_req_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rp_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [31:0] cfg_mask = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [12:0] req_len = '0;
    logic [2:0]  req_bar = '0;
    logic        req_wr = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_addr;
    logic [12:0] cmd_len;
    logic        cmd_wr;
    logic        ca_valid;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] log_addr [64];
    logic [12:0] log_len  [64];
    logic        log_wr   [64];
    int          log_n = 0;
    int          ca_cnt = 0;

    always #4 clk = ~clk;

    dn_req_xlate u0 (.*);

    always @(posedge clk) begin
        if (!rst) begin
            if (cmd_valid && cmd_ready && log_n < 64) begin
                log_addr[log_n] <= cmd_addr;
                log_len[log_n]  <= cmd_len;
                log_wr[log_n]   <= cmd_wr;
                log_n           <= log_n + 1;
            end
            if (ca_valid) ca_cnt <= ca_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    task automatic cfg(input logic [2:0] idx, input logic [31:0] b, input logic [31:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_base = b; cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] a, input logic [12:0] l, input logic [2:0] b, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l; req_bar = b; req_wr = w;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_cmd(input int i, input logic [31:0] a, input logic [12:0] l, input logic w, input string tag);
        check(log_addr[i] == a, {tag, " addr"}, 64'(log_addr[i]), 64'(a));
        check(log_len[i] == l,  {tag, " len"},  64'(log_len[i]),  64'(l));
        check(log_wr[i] == w,   {tag, " dir"},  64'(log_wr[i]),   64'(w));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        check(cmd_valid == 1'b0, "R1 cmd_valid", 64'(cmd_valid), 64'd0);
        check(ca_valid == 1'b0,  "R1 ca_valid",  64'(ca_valid),  64'd0);
    endtask

    task automatic t_endpoint();
        int b0;
        b0 = log_n;
        send(32'h0000_5123, 13'd64, 3'd0, 1'b0);
        send(32'hFFFF_ABCD, 13'd4, 3'd2, 1'b1);
        send(32'h1234_5678, 13'd8, 3'd1, 1'b0);
        settle();
        check(log_n == b0 + 3, "R2 count", 64'(log_n - b0), 64'd3);
        expect_cmd(b0,     32'h8000_0123, 13'd64, 1'b0, "R2 R4 bar0 read");
        expect_cmd(b0 + 1, 32'h1234_ABCD, 13'd4,  1'b1, "R2 bar2 write");
        expect_cmd(b0 + 2, 32'h0000_0000, 13'd8,  1'b0, "R1 unconfigured window");
    endtask

    task automatic t_rootport();
        int b0, c0;
        b0 = log_n; c0 = ca_cnt;
        @(negedge clk); rp_mode = 1'b1;
        send(32'hDEAD_BEE0, 13'd16, 3'd7, 1'b0);
        send(32'h0000_5123, 13'd32, 3'd0, 1'b0);
        settle();
        check(log_n == b0 + 2, "R3 count", 64'(log_n - b0), 64'd2);
        expect_cmd(b0,     32'hDEAD_BEE0, 13'd16, 1'b0, "R3 no-hit pass");
        expect_cmd(b0 + 1, 32'h0000_5123, 13'd32, 1'b0, "R3 bar0 pass");
        check(ca_cnt == c0, "R3 no abort", 64'(ca_cnt - c0), 64'd0);
        send(32'h0000_0100, 13'd0, 3'd0, 1'b0);
        settle();
        check(ca_cnt == c0 + 1, "R8 zero len rp abort", 64'(ca_cnt - c0), 64'd1);
        @(negedge clk); rp_mode = 1'b0;
    endtask

    task automatic t_split();
        int b0;
        logic [31:0] held;
        b0 = log_n;
        @(negedge clk); cmd_ready = 1'b0;
        send(32'h0010_0000, 13'd1300, 3'd5, 1'b0);
        held = cmd_addr;
        repeat (3) @(negedge clk);
        check(cmd_valid == 1'b1, "R10 valid held", 64'(cmd_valid), 64'd1);
        check(cmd_addr == held,  "R10 addr held",  64'(cmd_addr), 64'(held));
        check(req_ready == 1'b0, "R6 ready low",   64'(req_ready), 64'd0);
        cmd_ready = 1'b1;
        send(32'h0000_0040, 13'd8, 3'd0, 1'b0);
        settle();
        check(log_n == b0 + 4, "R5 count", 64'(log_n - b0), 64'd4);
        expect_cmd(b0,     32'hA010_0000, 13'd512, 1'b0, "R5 sub0");
        expect_cmd(b0 + 1, 32'hA010_0200, 13'd512, 1'b0, "R5 sub1");
        expect_cmd(b0 + 2, 32'hA010_0400, 13'd276, 1'b0, "R5 sub2");
        expect_cmd(b0 + 3, 32'h8000_0040, 13'd8,   1'b0, "R6 follower after split");
    endtask

    task automatic t_edges();
        int b0;
        b0 = log_n;
        send(32'h0000_0000, 13'd512, 3'd0, 1'b0);
        send(32'h0000_0000, 13'd513, 3'd0, 1'b0);
        send(32'h0000_0800, 13'd1024, 3'd0, 1'b1);
        settle();
        check(log_n == b0 + 4, "R4 R7 count", 64'(log_n - b0), 64'd4);
        expect_cmd(b0,     32'h8000_0000, 13'd512,  1'b0, "R4 exact 512");
        expect_cmd(b0 + 1, 32'h8000_0000, 13'd512,  1'b0, "R5 513 first");
        expect_cmd(b0 + 2, 32'h8000_0200, 13'd1,    1'b0, "R5 513 tail");
        expect_cmd(b0 + 3, 32'h8000_0800, 13'd1024, 1'b1, "R7 long write");
    endtask

    task automatic t_unsupported();
        int b0, c0, wide;
        b0 = log_n; c0 = ca_cnt; wide = 0;
        send(32'h0000_1000, 13'd16, 3'd6, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (ca_valid) wide++;
        end
        check(wide == 0, "R8 pulse one cycle", 64'(wide), 64'd0);
        check(ca_cnt == c0 + 1, "R8 no-hit read abort", 64'(ca_cnt - c0), 64'd1);
        send(32'h0000_1000, 13'd0, 3'd0, 1'b0);
        settle();
        check(ca_cnt == c0 + 2, "R8 zero len read abort", 64'(ca_cnt - c0), 64'd2);
        send(32'h0000_2000, 13'd8, 3'd7, 1'b1);
        send(32'h0000_2000, 13'd0, 3'd1, 1'b1);
        settle();
        check(ca_cnt == c0 + 2, "R9 write no abort", 64'(ca_cnt - c0), 64'd2);
        check(log_n == b0, "R8 R9 no command", 64'(log_n - b0), 64'd0);
    endtask

    task automatic t_cfg_oob();
        int b0;
        b0 = log_n;
        cfg(3'd6, 32'hFFFF_FFFF, 32'h0000_00FF);
        cfg(3'd7, 32'hFFFF_FFFF, 32'h0000_00FF);
        send(32'h0000_5123, 13'd4, 3'd0, 1'b0);
        send(32'h0000_5123, 13'd4, 3'd1, 1'b0);
        send(32'h0000_5123, 13'd4, 3'd4, 1'b0);
        settle();
        check(log_n == b0 + 3, "R11 count", 64'(log_n - b0), 64'd3);
        expect_cmd(b0,     32'h8000_0123, 13'd4, 1'b0, "R11 bar0 intact");
        expect_cmd(b0 + 1, 32'h0000_0000, 13'd4, 1'b0, "R11 bar1 intact");
        expect_cmd(b0 + 2, 32'h0000_0000, 13'd4, 1'b0, "R11 bar4 intact");
    endtask

    initial begin
        #(8 * 100000);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        cfg(3'd0, 32'h8000_0000, 32'h0000_0FFF);
        cfg(3'd2, 32'h1234_0000, 32'h0000_FFFF);
        cfg(3'd5, 32'hA000_0000, 32'h00FF_FFFF);
        t_endpoint();
        t_rootport();
        t_split();
        t_edges();
        t_unsupported();
        t_cfg_oob();
        finish_run();
    end

endmodule